// File: doc/BRIEF.md
# Serial DAC Input Register and Output Latch

This block is the digital front end of a serial-input voltage DAC. A host writes a word over a three-wire link: an active-low chip select, a serial clock and a data line. While chip select is low, each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. When chip select returns high, the register contents move into the DAC latch. The latch drives the code that goes to the converter core.

The converter resolution can be 12, 14 or 16 bits. Narrower words stay left-justified in the 16-bit frame, so their trailing bits are don't-care and are dropped. The latched code is right-aligned to the configured resolution. A unipolar build resets and clears to zero-scale. A bipolar build resets and clears to midscale. An active-low clear forces the latch to that code asynchronously. The serial pins are sampled on the system clock `clk`, which must run fast enough to see every level of the serial clock and chip select. A frame with fewer than 16 serial clock edges is flagged as a frame error. A one-cycle strobe marks each latch update made by a serial write.

Top module: `serdac_front`

## Requirements
- R1: With `cs_n` low, each rising edge of `sclk` shifts `din` into the low end of the 16-bit shift register, so the first bit sent ends up as bit 15 (MSB first).
- R2: With `cs_n` high, `sclk` edges and `din` have no effect on the shift register. A later frame with no clock edges latches the unchanged contents.
- R3: A low-to-high transition of `cs_n` copies the shift register into the latch. The new code and the strobe appear on the first `clk` edge that samples `cs_n` high.
- R4: When a frame has more than 16 `sclk` rising edges, only the last 16 bits shifted in reach the latch.
- R5: `frame_err_o` is updated at each `cs_n` rising edge. It is 1 if that frame had fewer than 16 `sclk` rising edges and 0 otherwise, and it holds its value between frames. The internal edge counter saturates at 16 and restarts on each `cs_n` falling edge.
- R6: `code_o` equals shift register bits 15 down to 16-RES. For RES = 14 or 12, the lowest 2 or 4 bits of the frame are dropped.
- R7: While `rst_n` is low, the latch holds the reset code, and `upd_o` and `frame_err_o` are 0. The reset code is 0 for unipolar builds (BIPOLAR=0). For bipolar builds it is 2^(RES-1): 32768, 8192 or 2048.
- R8: A low level on `clr_n` forces `code_o` to the reset code at once, without waiting for a `clk` edge. It leaves the shift register and the frame in progress untouched.
- R9: If `clr_n` is low when `cs_n` rises, the clear wins. The latch keeps the reset code and `upd_o` stays low.
- R10: `upd_o` is high for exactly one `clk` cycle for each latch update made by a serial write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low power-on reset |
| clr_n | input | 1 | Active-low asynchronous clear of the latch |
| cs_n | input | 1 | Active-low chip select that frames a word |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial data, MSB first |
| code_o | output | RES | Latched DAC code, right-aligned |
| upd_o | output | 1 | One-cycle strobe on a serial latch update |
| frame_err_o | output | 1 | Last frame had fewer than 16 clock edges |

## Verification
The bench builds all six parameter combinations side by side: RES of 16, 14 and 12, each as a unipolar and as a bipolar build. All six share one stimulus stream. Every frame therefore exercises left justification, bit dropping and both reset codes at the same moment, against a single arithmetic model of the shift register. Walking-one, all-ones, all-zeros and pseudo-random words cover every bit position. Short, empty and over-length frames reach the frame error and the keep-last-16 behaviour. Clears applied mid-frame and across a chip-select rise reach the asynchronous clear path and its priority in every build.

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int RES     = 16,
  parameter bit BIPOLAR = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           din,
  output logic [RES-1:0] code_o,
  output logic           upd_o,
  output logic           frame_err_o
);
  localparam int FW = 16;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [RES-1:0] RST_CODE = BIPOLAR ? {1'b1, {(RES-1){1'b0}}} : '0;

  logic          sclk_q, cs_q;
  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;

  wire shift_en = sclk & ~sclk_q & ~cs_n;
  wire cs_fall  = ~cs_n & cs_q;
  wire cs_rise  = cs_n & ~cs_q;
  wire latch_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (shift_en) sh <= {sh[FW-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (cs_fall)                  cnt <= shift_en ? CW'(1) : '0;
    else if (shift_en && cnt != FULL)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge latch_rst_n) begin
    if (!latch_rst_n)  code_o <= RST_CODE;
    else if (cs_rise)  code_o <= sh[FW-1 -: RES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_o       <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      upd_o <= cs_rise & clr_n;
      if (cs_rise) frame_err_o <= (cnt != FULL);
    end
  end

  p_hold_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> $stable(sh));

  p_count_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_clear_forces_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code_o == RST_CODE);

  p_clear_blocks_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && cs_rise) |=> !upd_o);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  p_code_changes_only_on_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && !upd_o) |-> $stable(code_o));
endmodule

// File: tb/serdac_front_tb.sv
module serdac_front_tb;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [15:0] code_a [NC];
  logic        upd_a  [NC];
  logic        err_a  [NC];
  int          upd_cnt [NC];
  int          upd_base [NC];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_sh = '0;
  logic [15:0] m_word = '0;
  bit          m_clr = 1'b1;
  bit          m_err = 1'b0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < NC; i++) begin : g_cfg
    localparam int GR = 16 - 2 * (i % 3);
    localparam bit GB = (i / 3) == 1;
    logic [GR-1:0] c;
    serdac_front #(.RES(GR), .BIPOLAR(GB)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk),
      .din(din), .code_o(c), .upd_o(upd_a[i]), .frame_err_o(err_a[i]));
    assign code_a[i] = 16'(c);
  end

  always @(negedge clk) begin
    for (int i = 0; i < NC; i++) if (upd_a[i]) upd_cnt[i]++;
  end

  function automatic int res_of(int i); return 16 - 2 * (i % 3); endfunction
  function automatic logic [15:0] rst_of(int i);
    return (i / 3 == 1) ? 16'(1) << (res_of(i) - 1) : 16'd0;
  endfunction
  function automatic logic [15:0] exp_of(int i);
    return m_clr ? rst_of(i) : (m_word >> (16 - res_of(i)));
  endfunction

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int i, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cfg%0d %s: actual %h expected %h", req, i, what, act, exp);
    end
  endtask

  task automatic chk_codes(string req);
    for (int i = 0; i < NC; i++) chk(req, i, "code", code_a[i], exp_of(i));
  endtask

  task automatic chk_err(string req);
    for (int i = 0; i < NC; i++) chk(req, i, "frame_err", 16'(err_a[i]), 16'(m_err));
  endtask

  task automatic mark_upd();
    for (int i = 0; i < NC; i++) upd_base[i] = upd_cnt[i];
  endtask

  task automatic chk_upd(string req, int exp);
    for (int i = 0; i < NC; i++) chk(req, i, "strobes", 16'(upd_cnt[i] - upd_base[i]), 16'(exp));
  endtask

  task automatic send_bit(logic b);
    sclk = 1'b0; din = b; step(2);
    sclk = 1'b1; step(2);
    m_sh = {m_sh[14:0], b};
  endtask

  task automatic open_frame(); cs_n = 1'b0; step(2); endtask

  task automatic close_frame(int nbits, bit clear_held);
    sclk = 1'b0; step(2);
    mark_upd();
    cs_n = 1'b1;
    step(1);
    if (!clear_held) begin m_word = m_sh; m_clr = 1'b0; end
    m_err = nbits < 16;
    step(3);
  endtask

  task automatic frame(logic [31:0] bits, int n, string req);
    open_frame();
    for (int k = n - 1; k >= 0; k--) send_bit(bits[k]);
    close_frame(n, 1'b0);
    chk_codes(req);
    chk_err("R5");
    chk_upd("R10", 1);
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    step(3);
    // R7: reset values
    chk_codes("R7");
    for (int i = 0; i < NC; i++) begin
      chk("R7", i, "upd", 16'(upd_a[i]), 16'd0);
      chk("R7", i, "frame_err", 16'(err_a[i]), 16'd0);
    end
    rst_n = 1'b1; step(3);
    chk_codes("R7");

    // R1 R3 R6: walking one over every bit position, then extremes
    for (int b = 0; b < 16; b++) frame(32'(16'h8000 >> b), 16, "R1_R6");
    frame(32'hFFFF, 16, "R3");
    frame(32'h0000, 16, "R3");
    for (int t = 0; t < 40; t++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      frame(32'(lf), 16, "R6");
    end

    // R4: over-length frames keep the last 16 bits
    frame(32'h000F_1234, 20, "R4");
    frame(32'h0001_5A5A, 17, "R4");
    frame(32'hFFFF_FFFF, 32, "R4");

    // R5: short and empty frames raise the frame error
    frame(32'h0000_02A5, 10, "R5");
    frame(32'h0, 0, "R5");
    frame(32'h0000_C3C3, 16, "R5");

    // R2: clock edges while deselected are ignored
    for (int k = 0; k < 8; k++) begin
      din = k[0]; sclk = 1'b1; step(2); sclk = 1'b0; step(2);
    end
    frame(32'h0, 0, "R2");

    // R8: asynchronous clear in the middle of a frame
    open_frame();
    for (int k = 7; k >= 0; k--) send_bit(1'(8'hB7 >> k));
    clr_n = 1'b0; #1;
    m_clr = 1'b1;
    chk_codes("R8");
    step(2); clr_n = 1'b1; step(2);
    chk_codes("R8");
    for (int k = 7; k >= 0; k--) send_bit(1'(8'h3C >> k));
    close_frame(16, 1'b0);
    chk_codes("R8");
    chk_upd("R10", 1);

    // R9: clear held across the chip-select rise wins
    open_frame();
    for (int k = 15; k >= 0; k--) send_bit(1'(16'h9E37 >> k));
    clr_n = 1'b0; step(1); m_clr = 1'b1;
    close_frame(16, 1'b1);
    chk_codes("R9");
    chk_upd("R9", 0);
    chk_err("R5");
    clr_n = 1'b1; step(3);
    chk_codes("R9");
    frame(32'h0, 0, "R9");

    // R7: reset returns everything to the reset state
    rst_n = 1'b0; #1;
    m_clr = 1'b1; m_err = 1'b0; m_sh = '0;
    chk_codes("R7"); chk_err("R7");
    step(2); rst_n = 1'b1; step(2);
    frame(32'h0000_7001, 16, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule